// File: doc/BRIEF.md
# Periodic and Burst Pulse Pattern Generator

This block drives up to eight test lines with single-cycle pulses for rate characterization of a time-stamping front end. It runs on the same clock as the system under test and counts a 512-step pattern period, which matches one trigger period and divides the receiver's counter rollover. Each pulse therefore lands on the same rollover bins in every period. All enabled lines carry the same pattern.

In periodic mode a programmed number M of pulses, from 1 to 64, is spread as evenly as possible over the period. Pulse k goes on step floor(k*512/M). The step is found with a subtracting accumulator, so no divider is needed. In burst mode a packet of N pulses with S idle cycles between them starts on a period boundary. The packet is followed by at least one complete pulse-free period before the next one. A scan controller holds N and S. On each scan step it raises N by one if the efficiency flag says all words were collected, and otherwise raises S by one. Both values saturate, and saturation raises a done flag.

A start pulse realigns everything to step 0 and picks the mode. The control state machine has five states:
- STOP: reset state, no output.
- PERIODIC: accumulator pattern running.
- FIRE: one burst pulse.
- GAP: idle cycles between burst pulses.
- HOLD: waiting for period boundaries after a packet.

Transitions:
- start goes to FIRE (burst) or PERIODIC (periodic).
- FIRE goes to GAP while pulses remain in the packet, and to HOLD after the last one.
- GAP goes to FIRE after S idle cycles.
- HOLD goes to FIRE at step 0 of the first period that follows a complete pulse-free period.

Top module: `pulse_pattern_gen`

## Requirements
- R1: After reset pulse_out is 0 and stays 0 until start, burst_count is 1, burst_space is 1 and scan_done is 0.
- R2: In periodic mode, counting the cycle after the start edge as step 0, a pulse appears on exactly the steps floor(k*512/M) for k = 0..M-1, where M is the effective pattern_count.
- R3: The periodic pattern repeats unchanged every 512 cycles for as long as no new start arrives.
- R4: The effective periodic count is 1 when pattern_count is 0 and 64 when pattern_count exceeds 64; otherwise it equals pattern_count.
- R5: Every line whose ch_enable bit is 1 carries the common pulse, and every line whose bit is 0 stays low.
- R6: In burst mode, with step 0 the cycle after the start edge, pulse i of the packet (i = 0..N-1) is high on cycle i*(S+1), where N = burst_count and S = burst_space.
- R7: After a packet whose last pulse falls on cycle L, the next packet starts on cycle (floor(L/512)+2)*512, which is the first period start preceded by a complete pulse-free period. The sequence then repeats.
- R8: A scan_step with scan_efficient = 1 raises burst_count by 1 on the next cycle, saturating at 64, and leaves burst_space unchanged.
- R9: A scan_step with scan_efficient = 0 raises burst_space by 1 on the next cycle, saturating at 255, and leaves burst_count unchanged.
- R10: scan_load sets burst_count from load_count (0 becomes 1, above 64 becomes 64) and burst_space from load_space (0 becomes 1). It takes priority over scan_step. Without either input both values hold.
- R11: scan_done is 1 exactly when burst_count is 64 or burst_space is 255.
- R12: Every pulse lasts exactly one cycle, unless a start restarts the pattern.
- R13: burst_mode is sampled only on start. Changing it during a run does not alter the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the system under test |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Realigns to step 0 and samples the mode |
| burst_mode | input | 1 | 1 selects burst, 0 selects periodic (sampled at start) |
| ch_enable | input | 8 | Per-line enable mask |
| pattern_count | input | 7 | Pulses per period in periodic mode |
| scan_load | input | 1 | Loads burst count and spacing |
| load_count | input | 7 | Burst count value to load |
| load_space | input | 8 | Burst spacing value to load |
| scan_step | input | 1 | Advances the scan by one step |
| scan_efficient | input | 1 | 1 when the last setting lost no words |
| pulse_out | output | 8 | Test pulse lines |
| burst_count | output | 7 | Current packet size N |
| burst_space | output | 8 | Current idle cycles between burst pulses S |
| scan_done | output | 1 | Scan value saturated |

## Verification
A corrupted step counter or accumulator shows up as a pulse off its computed step within the first period after start. A wrong state transition shows up as a missing, doubled or early packet; in the worst case this becomes visible one full repetition later, which is three periods at most for the configurations used. Scan register errors appear on burst_count, burst_space or scan_done on the cycle after the step or load. The bench sweeps many counts, masks and burst shapes, including packets that end exactly on and just past a period boundary, and checks every cycle against arithmetic expectations.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_PERIODIC,
        ST_FIRE,
        ST_GAP,
        ST_HOLD
    } gen_state_t;

endpackage

// File: rtl/pps_step_counter.sv
// Pattern step counter plus the subtracting accumulator that places
// periodic pulses at floor(k*2^STEP_W/M) without a divider.
module pps_step_counter #(
    parameter int STEP_W = 9,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  m_count,
    output logic [STEP_W-1:0] step,
    output logic              hit
);

    logic [STEP_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= '0;
            acc_q <= '0;
        end else if (start) begin
            step  <= '0;
            acc_q <= '0;
        end else begin
            step  <= step + STEP_W'(1);
            acc_q <= acc_q - STEP_W'(m_count);
        end
    end

    // acc_q holds (-step*M) mod 2^STEP_W; a multiple of the period lies in
    // [step*M, step*M+M) exactly when this residue is below M.
    assign hit = (acc_q < STEP_W'(m_count));

endmodule

// File: rtl/pps_scan_ctrl.sv
module pps_scan_ctrl #(
    parameter int MAX_COUNT = 64,
    parameter int CNT_W     = 7,
    parameter int SPACE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_load,
    input  logic [CNT_W-1:0]   load_count,
    input  logic [SPACE_W-1:0] load_space,
    input  logic               scan_step,
    input  logic               scan_efficient,
    output logic [CNT_W-1:0]   n_count,
    output logic [SPACE_W-1:0] n_space,
    output logic               done
);

    localparam logic [CNT_W-1:0]   CNT_MAX   = CNT_W'(MAX_COUNT);
    localparam logic [SPACE_W-1:0] SPACE_MAX = '1;

    logic [CNT_W-1:0]   load_cnt_c;
    logic [SPACE_W-1:0] load_spc_c;

    always_comb begin
        if (load_count == '0)
            load_cnt_c = CNT_W'(1);
        else if (load_count > CNT_MAX)
            load_cnt_c = CNT_MAX;
        else
            load_cnt_c = load_count;
        load_spc_c = (load_space == '0) ? SPACE_W'(1) : load_space;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_count <= CNT_W'(1);
            n_space <= SPACE_W'(1);
        end else if (scan_load) begin
            n_count <= load_cnt_c;
            n_space <= load_spc_c;
        end else if (scan_step) begin
            if (scan_efficient) begin
                if (n_count < CNT_MAX)
                    n_count <= n_count + CNT_W'(1);
            end else if (n_space != SPACE_MAX) begin
                n_space <= n_space + SPACE_W'(1);
            end
        end
    end

    assign done = (n_count == CNT_MAX) || (n_space == SPACE_MAX);

endmodule

// File: rtl/pps_burst_fsm.sv
module pps_burst_fsm
    import pps_pkg::*;
#(
    parameter int STEP_W  = 9,
    parameter int CNT_W   = 7,
    parameter int SPACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               burst_mode,
    input  logic [STEP_W-1:0]  step,
    input  logic [CNT_W-1:0]   n_count,
    input  logic [SPACE_W-1:0] n_space,
    output logic               fire,
    output logic               periodic_run
);

    gen_state_t         state_q, state_d;
    logic [CNT_W-1:0]   pcnt_q, pcnt_d;
    logic [SPACE_W-1:0] gcnt_q, gcnt_d;
    logic               bnd_q, bnd_d;
    logic               step_last;

    assign step_last = (step == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            pcnt_q  <= '0;
            gcnt_q  <= '0;
            bnd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            gcnt_q  <= gcnt_d;
            bnd_q   <= bnd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        gcnt_d  = gcnt_q;
        bnd_d   = bnd_q;
        if (start) begin
            pcnt_d  = '0;
            gcnt_d  = '0;
            bnd_d   = 1'b0;
            state_d = burst_mode ? ST_FIRE : ST_PERIODIC;
        end else begin
            unique case (state_q)
                ST_STOP, ST_PERIODIC: begin
                    state_d = state_q;
                end
                ST_FIRE: begin
                    if ((pcnt_q + CNT_W'(1)) >= n_count) begin
                        state_d = ST_HOLD;
                        bnd_d   = step_last;
                    end else begin
                        state_d = ST_GAP;
                        gcnt_d  = '0;
                        pcnt_d  = pcnt_q + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if ((gcnt_q + SPACE_W'(1)) >= n_space)
                        state_d = ST_FIRE;
                    else
                        gcnt_d = gcnt_q + SPACE_W'(1);
                end
                ST_HOLD: begin
                    if (step_last) begin
                        if (bnd_q) begin
                            state_d = ST_FIRE;
                            pcnt_d  = '0;
                        end else begin
                            bnd_d = 1'b1;
                        end
                    end
                end
                default: state_d = ST_STOP;
            endcase
        end
    end

    always_comb begin
        fire         = (state_q == ST_FIRE);
        periodic_run = (state_q == ST_PERIODIC);
    end

endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen #(
    parameter int NUM_CH    = 8,
    parameter int STEP_W    = 9,
    parameter int MAX_COUNT = 64,
    parameter int SPACE_W   = 8,
    localparam int CNT_W    = $clog2(MAX_COUNT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               burst_mode,
    input  logic [NUM_CH-1:0]  ch_enable,
    input  logic [CNT_W-1:0]   pattern_count,
    input  logic               scan_load,
    input  logic [CNT_W-1:0]   load_count,
    input  logic [SPACE_W-1:0] load_space,
    input  logic               scan_step,
    input  logic               scan_efficient,
    output logic [NUM_CH-1:0]  pulse_out,
    output logic [CNT_W-1:0]   burst_count,
    output logic [SPACE_W-1:0] burst_space,
    output logic               scan_done
);

    logic [CNT_W-1:0]  m_eff;
    logic [STEP_W-1:0] step;
    logic              hit;
    logic              fire;
    logic              periodic_run;
    logic              pulse;

    always_comb begin
        if (pattern_count == '0)
            m_eff = CNT_W'(1);
        else if (pattern_count > CNT_W'(MAX_COUNT))
            m_eff = CNT_W'(MAX_COUNT);
        else
            m_eff = pattern_count;
    end

    pps_step_counter #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .m_count (m_eff),
        .step    (step),
        .hit     (hit)
    );

    pps_scan_ctrl #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .scan_load      (scan_load),
        .load_count     (load_count),
        .load_space     (load_space),
        .scan_step      (scan_step),
        .scan_efficient (scan_efficient),
        .n_count        (burst_count),
        .n_space        (burst_space),
        .done           (scan_done)
    );

    pps_burst_fsm #(.STEP_W(STEP_W), .CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .burst_mode   (burst_mode),
        .step         (step),
        .n_count      (burst_count),
        .n_space      (burst_space),
        .fire         (fire),
        .periodic_run (periodic_run)
    );

    assign pulse = periodic_run ? hit : fire;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_line
            assign pulse_out[c] = pulse & ch_enable[c];
        end
    endgenerate

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int NUM_CH    = 8,
    parameter int MAX_COUNT = 64,
    parameter int SPACE_W   = 8,
    parameter int CNT_W     = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               scan_load,
    input logic               scan_step,
    input logic               scan_efficient,
    input logic [NUM_CH-1:0]  pulse_out,
    input logic [CNT_W-1:0]   burst_count,
    input logic [SPACE_W-1:0] burst_space,
    input logic               scan_done
);

    localparam logic [SPACE_W-1:0] SPACE_MAX = '1;

    // R12: a pulse never stretches into a second cycle without a restart
    a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pulse_out) && !start) |=> !(|pulse_out));

    // R8: efficient step raises the packet size below saturation
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_step && scan_efficient && !scan_load && burst_count < CNT_W'(MAX_COUNT))
        |=> (burst_count == $past(burst_count) + CNT_W'(1)) && $stable(burst_space));

    // R9: inefficient step widens the spacing below saturation
    a_r9_space_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_step && !scan_efficient && !scan_load && burst_space != SPACE_MAX)
        |=> (burst_space == $past(burst_space) + SPACE_W'(1)) && $stable(burst_count));

    // R10: scan values hold without step or load
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_step && !scan_load) |=> $stable(burst_count) && $stable(burst_space));

    // R11: saturation persists until a new load
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && !scan_load) |=> scan_done);

    // R10: values always stay inside their legal ranges
    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_count != '0) && (burst_count <= CNT_W'(MAX_COUNT)) && (burst_space != '0));

endmodule

bind pulse_pattern_gen pps_checker #(
    .NUM_CH    (NUM_CH),
    .MAX_COUNT (MAX_COUNT),
    .SPACE_W   (SPACE_W),
    .CNT_W     (CNT_W)
) u_pps_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .scan_load      (scan_load),
    .scan_step      (scan_step),
    .scan_efficient (scan_efficient),
    .pulse_out      (pulse_out),
    .burst_count    (burst_count),
    .burst_space    (burst_space),
    .scan_done      (scan_done)
);

// File: tb/tb_pulse_pattern_gen.sv
`timescale 1ns/1ps
module tb_pulse_pattern_gen;

    localparam int PER = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       burst_mode = 1'b0;
    logic [7:0] ch_enable = 8'hFF;
    logic [6:0] pattern_count = 7'd1;
    logic       scan_load = 1'b0;
    logic [6:0] load_count = 7'd1;
    logic [7:0] load_space = 8'd1;
    logic       scan_step = 1'b0;
    logic       scan_efficient = 1'b0;
    logic [7:0] pulse_out;
    logic [6:0] burst_count;
    logic [7:0] burst_space;
    logic       scan_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pulse_pattern_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_mode(burst_mode),
        .ch_enable(ch_enable), .pattern_count(pattern_count),
        .scan_load(scan_load), .load_count(load_count), .load_space(load_space),
        .scan_step(scan_step), .scan_efficient(scan_efficient),
        .pulse_out(pulse_out), .burst_count(burst_count),
        .burst_space(burst_space), .scan_done(scan_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input int s, input int m);
        for (int k = 0; k < m; k++)
            if ((k * PER) / m == s) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_burst(input int t, input int n, input int sp);
        int last = (n - 1) * (sp + 1);
        int c = ((last / PER) + 2) * PER;
        int r = t % c;
        return (r <= last) && ((r % (sp + 1)) == 0);
    endfunction

    task automatic do_start(input bit bm);
        @(negedge clk);
        burst_mode = bm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Observes 'periods' periods; returns mismatches and pulse count.
    task automatic watch_periodic(input int m, input logic [7:0] en, input int periods,
                                  output int bad, output int pulses, output int first_act,
                                  output int first_exp);
        bad = 0; pulses = 0; first_act = 0; first_exp = 0;
        for (int t = 0; t < periods * PER; t++) begin
            logic [7:0] e;
            e = exp_hit(t % PER, m) ? en : 8'h00;
            if (pulse_out !== e) begin
                if (bad == 0) begin first_act = int'(pulse_out); first_exp = int'(e); end
                bad++;
            end
            if (pulse_out != 8'h00) pulses++;
            @(negedge clk);
        end
    endtask

    task automatic run_periodic(input int m_in, input int m_exp, input logic [7:0] en,
                                input string req);
        int bad, pulses, fa, fe;
        pattern_count = 7'(m_in);
        ch_enable = en;
        do_start(1'b0);
        watch_periodic(m_exp, en, 2, bad, pulses, fa, fe);
        check(bad == 0, req, fa, fe);
        if (en != 8'h00)
            check(pulses == 2 * m_exp, "R3 pulses over two periods", pulses, 2 * m_exp);
    endtask

    task automatic load_scan(input int n, input int sp);
        @(negedge clk);
        load_count = 7'(n);
        load_space = 8'(sp);
        scan_load = 1'b1;
        @(negedge clk);
        scan_load = 1'b0;
    endtask

    task automatic run_burst(input int n, input int sp);
        int last = (n - 1) * (sp + 1);
        int c = ((last / PER) + 2) * PER;
        int bad1 = 0, bad2 = 0, fa = 0, fe = 0;
        load_scan(n, sp);
        ch_enable = 8'hFF;
        do_start(1'b1);
        for (int t = 0; t < 2 * c + 64; t++) begin
            logic [7:0] e;
            e = exp_burst(t, n, sp) ? 8'hFF : 8'h00;
            if (pulse_out !== e) begin
                if (bad1 + bad2 == 0) begin fa = t; fe = int'(e); end
                if (t < c) bad1++; else bad2++;
            end
            @(negedge clk);
        end
        check(bad1 == 0, "R6 packet shape (act=first bad cycle)", fa, fe);
        check(bad2 == 0, "R7 packet repetition (act=first bad cycle)", fa, fe);
    endtask

    task automatic scan_op(input bit ld, input bit st, input bit eff);
        @(negedge clk);
        scan_load = ld;
        scan_step = st;
        scan_efficient = eff;
        @(negedge clk);
        scan_load = 1'b0;
        scan_step = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int bad, pulses, fa, fe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(burst_count == 7'd1, "R1 count after reset", int'(burst_count), 1);
        check(burst_space == 8'd1, "R1 space after reset", int'(burst_space), 1);
        check(scan_done == 1'b0, "R1 done after reset", int'(scan_done), 0);
        bad = 0;
        for (int t = 0; t < 600; t++) begin
            if (pulse_out != 8'h00) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R1 silent before start", bad, 0);

        // R2 R3 sweep of periodic counts
        run_periodic(1, 1, 8'hFF, "R2 M=1");
        run_periodic(2, 2, 8'hFF, "R2 M=2");
        run_periodic(3, 3, 8'hFF, "R2 M=3");
        run_periodic(7, 7, 8'hFF, "R2 M=7");
        run_periodic(37, 37, 8'hFF, "R2 M=37");
        run_periodic(63, 63, 8'hFF, "R2 M=63");
        run_periodic(64, 64, 8'hFF, "R2 M=64");
        // R4 clamping
        run_periodic(0, 1, 8'hFF, "R4 count 0 acts as 1");
        run_periodic(100, 64, 8'hFF, "R4 count 100 acts as 64");
        // R5 masks
        run_periodic(5, 5, 8'h5A, "R5 mask 5A");
        run_periodic(9, 9, 8'h00, "R5 mask 00");
        run_periodic(11, 11, 8'h81, "R5 mask 81");

        // R13: mode flip mid-run leaves periodic pattern intact
        pattern_count = 7'd5;
        ch_enable = 8'hFF;
        do_start(1'b0);
        burst_mode = 1'b1;
        watch_periodic(5, 8'hFF, 2, bad, pulses, fa, fe);
        check(bad == 0, "R13 mode ignored without start", fa, fe);

        // R6 R7 burst shapes incl. boundary cases
        run_burst(1, 1);
        run_burst(3, 2);
        run_burst(8, 72);   // last pulse on step 511
        run_burst(9, 63);   // last pulse on step 0 of next period
        run_burst(64, 10);  // packet longer than a period
        burst_mode = 1'b0;

        // R10 load, R8 R9 steps, R11 done
        load_scan(10, 5);
        check(burst_count == 7'd10 && burst_space == 8'd5, "R10 load",
              int'(burst_count), 10);
        scan_op(1'b0, 1'b1, 1'b1);
        check(burst_count == 7'd11, "R8 efficient step", int'(burst_count), 11);
        check(burst_space == 8'd5, "R8 space unchanged", int'(burst_space), 5);
        scan_op(1'b0, 1'b1, 1'b0);
        check(burst_space == 8'd6, "R9 inefficient step", int'(burst_space), 6);
        check(burst_count == 7'd11, "R9 count unchanged", int'(burst_count), 11);
        load_count = 7'd20; load_space = 8'd30;
        scan_op(1'b1, 1'b1, 1'b1);
        check(burst_count == 7'd20 && burst_space == 8'd30, "R10 load beats step",
              int'(burst_count), 20);
        load_scan(63, 3);
        check(scan_done == 1'b0, "R11 done low at 63", int'(scan_done), 0);
        scan_op(1'b0, 1'b1, 1'b1);
        check(burst_count == 7'd64, "R8 reach 64", int'(burst_count), 64);
        check(scan_done == 1'b1, "R11 done at count 64", int'(scan_done), 1);
        scan_op(1'b0, 1'b1, 1'b1);
        check(burst_count == 7'd64, "R8 saturate 64", int'(burst_count), 64);
        load_scan(0, 0);
        check(burst_count == 7'd1 && burst_space == 8'd1, "R10 zero load clamps",
              int'(burst_count), 1);
        load_scan(120, 254);
        check(burst_count == 7'd64, "R10 high load clamps", int'(burst_count), 64);
        load_scan(5, 254);
        scan_op(1'b0, 1'b1, 1'b0);
        check(burst_space == 8'd255, "R9 reach 255", int'(burst_space), 255);
        check(scan_done == 1'b1, "R11 done at space 255", int'(scan_done), 1);
        scan_op(1'b0, 1'b1, 1'b0);
        check(burst_space == 8'd255, "R9 saturate 255", int'(burst_space), 255);
        repeat (4) @(negedge clk);
        check(burst_count == 7'd5 && burst_space == 8'd255, "R10 hold when idle",
              int'(burst_count), 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // R12 is also covered by the single-cycle property in the checker.

endmodule